// File: doc/BRIEF.md
# Character Cell Video Serializer

This block turns the address stream of a CRT timing generator into a one-bit pixel stream. Each character clock it takes the screen address and the scan-line count, reads the character code from an on-chip screen store, looks up the pixel row for that line in a computed character-pattern table, applies per-character and whole-screen inversion plus blanking, and shifts the pixels out one per clock. The clock of the block is the pixel clock.

Two widths are supported. In narrow mode one byte is fetched per character cell and eight pixels leave the block. In wide mode the screen store is read as two parallel byte banks, so two adjacent bytes are fetched per cell and sixteen pixels leave within one cell. Spare high address bits from the timing generator select an alternate character set and invert the whole picture, and a separate input picks the lower-case pattern set. The screen store is loaded through a simple synchronous byte write port.

Top module: `char_video_serializer`

## Requirements
- R1: During reset and after it, `video_o` is 0; after reset the block runs in narrow mode, so the first character is taken in at the 8th rising edge after reset is released, and outputs stay 0 until then.
- R2: The pattern row for code C on line R is ((C[6:0]*3 + R[2:0]*17) mod 256), XOR 8'hA5 when the alternate set is selected, XOR 8'h3C when `lower_i` is 1; only code bits 6..0 and line bits 2..0 address it.
- R3: When code bit 7 is 1, every pixel of that character's row is inverted.
- R4: When `ra_i` is 8 or more (bits 4..3 not both zero), the character's pixels are 0 whatever the code, including bit 7.
- R5: When `de_i` is 0 at a character load, all pixels of that cell are 0 before the whole-screen inversion.
- R6: `ma_i[12]` at a load inverts every pixel of the cell, including blanked cells and lines of R4 and R5.
- R7: `ma_i[13]` selects the alternate character set of R2.
- R8: Pixels of a row leave most significant bit first, one per clock; the next cell is loaded on the clock edge that ends the last pixel, and all inputs are sampled at that edge.
- R9: In wide mode (`wide_i`=1) a cell yields 16 pixels: the row of byte 2*MA first, then that of byte 2*MA+1, with MA = `ma_i[9:0]`.
- R10: In narrow mode the byte at linear address `ma_i[9:0]` is used; `ma_i[11:10]` have no effect in either mode.
- R11: A write with `wr_en_i`=1 stores `wr_data_i` at byte address `wr_addr_i` on the rising edge, even during reset; even addresses form one bank, odd addresses the other.
- R12: The width mode is sampled at each load, so switching `wide_i` takes effect cleanly on the next cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_i | input | 1 | 1 = two bytes per cell (16 pixels), 0 = one byte (8 pixels) |
| lower_i | input | 1 | Selects the lower-case pattern set |
| de_i | input | 1 | Display enable from the timing generator |
| ma_i | input | 14 | Memory address; bits 9..0 screen, 12 screen invert, 13 alternate set |
| ra_i | input | 5 | Scan-line count within the character row |
| wr_en_i | input | 1 | Screen store write strobe |
| wr_addr_i | input | 11 | Screen store byte address |
| wr_data_i | input | 8 | Screen store write data |
| video_o | output | 1 | Serial pixel output |

## Verification
A pixel counter that drifts would move the cell boundary, so every later cell would appear shifted by whole pixels and the mismatch shows in the first cell after the fault. A wrong bank or index selection shows as the pattern of a neighbouring byte at the first pixel of the affected cell, and a lost inversion or blanking flag shows in the first pixel after the load. The bench sweeps every code on every line in both widths, with display enable and both inversions toggled, so any of these faults is seen within one cell of a few hundred.

// File: rtl/cvs_pkg.sv
// Shared constants and the computed character-pattern function.
// Assumes the pattern table is arithmetic, so no stored table is needed.
package cvs_pkg;
    localparam int BYTE_W   = 8;
    localparam int LANES    = 2;
    localparam int MA_W     = 14;
    localparam int RA_W     = 5;
    localparam int SCR_W    = 10;
    localparam int INV_BIT  = 12;
    localparam int ALT_BIT  = 13;
    localparam int ROW_BITS = 3;

    // Pattern row for a 7-bit code on a given line of the cell.
    function automatic logic [7:0] glyph_bits(
        input logic [6:0] code,
        input logic [2:0] row,
        input logic       alt,
        input logic       lower
    );
        logic [8:0] s;
        s = ({2'b00, code} + {1'b0, code, 1'b0}) + ({2'b00, row, 4'b0000} + {6'b000000, row});
        return s[7:0] ^ (alt ? 8'hA5 : 8'h00) ^ (lower ? 8'h3C : 8'h00);
    endfunction
endpackage

// File: rtl/cvs_screen_ram.sv
// Screen store as parallel byte banks: bank k holds bytes whose address
// modulo BANKS equals k. All banks are read at one index without latency.
// Assumes writes are synchronous and the contents are not reset.
module cvs_screen_ram #(
    parameter int IDX_W = 10,
    parameter int BANKS = 2,
    parameter int DW    = 8
) (
    input  logic                          clk,
    input  logic                          wr_en_i,
    input  logic [IDX_W+$clog2(BANKS)-1:0] wr_addr_i,
    input  logic [DW-1:0]                 wr_data_i,
    input  logic [IDX_W-1:0]              rd_idx_i,
    output logic [BANKS*DW-1:0]           rd_data_o
);
    localparam int SEL_W = $clog2(BANKS);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];

        // Store a byte into this bank when the low address bits pick it.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_addr_i[SEL_W-1:0] == SEL_W'(b)))
                mem[wr_addr_i[IDX_W+SEL_W-1:SEL_W]] <= wr_data_i;
        end

        assign rd_data_o[b*DW +: DW] = mem[rd_idx_i];
    end
endmodule

// File: rtl/cvs_glyph_rom.sv
// One lane of pattern lookup: code bit 7 inverts the row, lines past the
// last pattern line are forced dark. Purely combinational.
module cvs_glyph_rom
    import cvs_pkg::*;
#(
    parameter int RW = RA_W
) (
    input  logic [7:0]    code_i,
    input  logic [RW-1:0] ra_i,
    input  logic          alt_i,
    input  logic          lower_i,
    output logic [7:0]    row_o
);
    logic tall_line;

    assign tall_line = (ra_i[RW-1:ROW_BITS] != '0);

    // Look up, apply per-character inversion, then blank tall lines.
    always_comb begin
        row_o = glyph_bits(code_i[6:0], ra_i[ROW_BITS-1:0], alt_i, lower_i)
                ^ {8{code_i[7]}};
        if (tall_line)
            row_o = 8'h00;
    end
endmodule

// File: rtl/cvs_pixel_shifter.sv
// Pixel shift register with its cell counter. Loads a new word on the edge
// that ends the last pixel of a cell and shifts MSB first otherwise.
// Assumes the narrow cell is one lane, the wide cell all lanes.
module cvs_pixel_shifter #(
    parameter int BW    = 8,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES*BW-1:0] word_i,
    input  logic                wide_i,
    input  logic                de_i,
    input  logic                inv_i,
    output logic                load_o,
    output logic                video_o
);
    localparam int W     = LANES * BW;
    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] px_cnt;
    logic [CNT_W-1:0] last;
    logic [W-1:0]     sr;
    logic             wide_q, de_q, inv_q;

    assign last   = wide_q ? CNT_W'(W - 1) : CNT_W'(BW - 1);
    assign load_o = (px_cnt == last);

    // Reload the cell on its final pixel, otherwise advance one pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_cnt <= '0;
            sr     <= '0;
            wide_q <= 1'b0;
            de_q   <= 1'b0;
            inv_q  <= 1'b0;
        end else if (load_o) begin
            px_cnt <= '0;
            sr     <= word_i;
            wide_q <= wide_i;
            de_q   <= de_i;
            inv_q  <= inv_i;
        end else begin
            px_cnt <= px_cnt + 1'b1;
            sr     <= {sr[W-2:0], 1'b0};
        end
    end

    assign video_o = (de_q & sr[W-1]) ^ inv_q;

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        px_cnt <= last);

    assert_msb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |=> (sr == {$past(sr[W-2:0]), 1'b0}));
endmodule

// File: rtl/char_video_serializer.sv
// Character cell video serializer. Fetches one (narrow) or two (wide)
// character codes per cell from the screen store, looks up their rows,
// and serializes them. Assumes ma_i/ra_i/de_i are stable around the load
// edge, as a timing generator clocked per cell provides.
module char_video_serializer
    import cvs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_i,
    input  logic            lower_i,
    input  logic            de_i,
    input  logic [MA_W-1:0] ma_i,
    input  logic [RA_W-1:0] ra_i,
    input  logic            wr_en_i,
    input  logic [SCR_W:0]  wr_addr_i,
    input  logic [7:0]      wr_data_i,
    output logic            video_o
);
    localparam int WORD_W = LANES * BYTE_W;

    logic [SCR_W-1:0]    rd_idx;
    logic [WORD_W-1:0]   bank_q;
    logic [7:0]          code [LANES];
    logic [7:0]          row  [LANES];
    logic [WORD_W-1:0]   word;
    logic                load;

    // Wide mode indexes both banks by MA; narrow mode splits MA into index and bank.
    assign rd_idx = wide_i ? ma_i[SCR_W-1:0] : {1'b0, ma_i[SCR_W-1:1]};

    cvs_screen_ram #(.IDX_W(SCR_W), .BANKS(LANES), .DW(BYTE_W)) u_ram (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (bank_q)
    );

    // Lane 0 takes the byte the narrow address picks; lane 1 the odd bank.
    always_comb begin
        code[0] = (!wide_i && ma_i[0]) ? bank_q[BYTE_W +: BYTE_W] : bank_q[0 +: BYTE_W];
        code[1] = bank_q[BYTE_W +: BYTE_W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cvs_glyph_rom #(.RW(RA_W)) u_rom (
            .code_i  (code[l]),
            .ra_i    (ra_i),
            .alt_i   (ma_i[ALT_BIT]),
            .lower_i (lower_i),
            .row_o   (row[l])
        );
    end

    // Pack lanes first-out at the top; narrow mode pads with dark pixels.
    assign word = wide_i ? {row[0], row[1]} : {row[0], 8'h00};

    cvs_pixel_shifter #(.BW(BYTE_W), .LANES(LANES)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (word),
        .wide_i  (wide_i),
        .de_i    (de_i),
        .inv_i   (ma_i[INV_BIT]),
        .load_o  (load),
        .video_o (video_o)
    );

    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |=> (video_o == 1'b0));

    assert_blank_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !de_i) |=> (video_o == $past(ma_i[INV_BIT])));

    assert_tall_rows_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && de_i && (ra_i[RA_W-1:ROW_BITS] != '0)) |=> (video_o == $past(ma_i[INV_BIT])));
endmodule

// File: tb/char_video_serializer_bench.sv
module char_video_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_i = 1'b0, lower_i = 1'b0, de_i = 1'b0;
    logic [13:0] ma_i = '0;
    logic [4:0]  ra_i = '0;
    logic        wr_en_i = 1'b0;
    logic [10:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        video_o;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] model [2048];

    always #4 clk = ~clk;

    char_video_serializer u_char_video_serializer (
        .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .lower_i(lower_i), .de_i(de_i),
        .ma_i(ma_i), .ra_i(ra_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .video_o(video_o)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below 200000", cycles);
            summary();
        end
    end

    function automatic logic [7:0] exp_row(input logic [7:0] code, input logic [4:0] ra,
                                           input bit alt, input bit lower);
        int s;
        logic [7:0] r;
        s = (int'(code[6:0]) * 3 + int'(ra[2:0]) * 17) % 256;
        r = 8'(s) ^ (alt ? 8'hA5 : 8'h00) ^ (lower ? 8'h3C : 8'h00);
        if (code[7]) r = ~r;
        if (ra > 5'd7) r = 8'h00;
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench writes at negedge; committed at the next rising edge.
    task automatic write_byte(input int a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = 11'(a); wr_data_i = d;
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
        model[a] = d;
    endtask

    // Reset, optionally filling, then 7 edges up to one before first load.
    task automatic do_reset(input bit fill);
        @(negedge clk);
        rst_n = 1'b0;
        de_i = 1'b1; ma_i = 14'h1000; wide_i = 1'b1;
        if (fill) for (int a = 0; a < 2048; a++) write_byte(a, 8'((a * 37 + 11) % 256));
        else begin @(posedge clk); @(negedge clk); end
        check("R1 reset level", {15'd0, video_o}, 16'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 7; k++) begin
            @(posedge clk); @(negedge clk);
            check("R1 dark until first narrow load", {15'd0, video_o}, 16'd0);
        end
    endtask

    // Drive one cell right before its load edge and capture its pixels.
    task automatic run_cell(input string tag, input logic [13:0] ma, input logic [4:0] ra,
                            input bit de, input bit lower, input bit wide);
        logic [15:0] act, exp;
        int n, base;
        bit alt, inv;
        ma_i = ma; ra_i = ra; de_i = de; lower_i = lower; wide_i = wide;
        alt = ma[13]; inv = ma[12];
        n = wide ? 16 : 8;
        if (wide) begin
            base = 2 * int'(ma[9:0]);
            exp = {exp_row(model[base], ra, alt, lower), exp_row(model[base + 1], ra, alt, lower)};
        end else begin
            exp = {exp_row(model[int'(ma[9:0])], ra, alt, lower), 8'h00};
        end
        if (!de) exp = 16'h0000;
        if (inv) exp = ~exp;
        if (!wide) exp[7:0] = 8'h00;
        act = '0;
        @(posedge clk);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            act[15 - p] = video_o;
            if (p < n - 1) @(posedge clk);
        end
        check(tag, act, exp);
    endtask

    initial begin
        do_reset(1'b1);

        // R2 R3 R4 R6 R8 R10: narrow sweep over all codes, lines 0..9, noisy MA[11:10].
        for (int r = 0; r < 10; r++)
            for (int a = 0; a < 256; a++)
                run_cell("R2 R3 R4 R6 R8 R10 narrow sweep",
                         {1'b0, 1'(a >> 3), 2'(a >> 4), 10'((a * 5 + r * 3) % 1024)},
                         5'(r), 1'b1, 1'b0, 1'b0);

        // R7: alternate set and lower-case set together and apart.
        for (int r = 0; r < 8; r++)
            for (int a = 0; a < 256; a++)
                run_cell("R7 alternate and lower sets",
                         {1'(a), 1'(r), 2'b10, 10'((a * 3 + r) % 1024)},
                         5'(r), 1'b1, 1'(a >> 1), 1'b0);

        // R5 R6: display enable low, with and without whole-screen inversion.
        for (int a = 0; a < 64; a++)
            run_cell("R5 R6 blank cell", {1'b0, 1'(a), 2'b01, 10'(a * 11)},
                     5'(a % 8), 1'b0, 1'b0, 1'(a >> 5));

        // R9 R10: wide sweep, two bytes per cell, MA[11:10] noisy.
        for (int r = 0; r < 10; r++)
            for (int a = 0; a < 128; a++)
                run_cell("R9 R10 wide sweep",
                         {1'(a >> 6), 1'(a >> 2), 2'(a), 10'((a * 9 + r) % 1024)},
                         5'(r), 1'b1, 1'(r), 1'b1);

        // R12: width toggles on every cell.
        for (int a = 0; a < 32; a++)
            run_cell("R12 width switch at load", {4'b0000, 10'(a * 31)},
                     5'(a % 10), 1'b1, 1'b0, 1'(a));

        // R11: rewrite under reset, read back in both widths and both banks.
        do_reset(1'b0);
        @(negedge clk); rst_n = 1'b0;
        write_byte(5, 8'h81);
        write_byte(4, 8'h7E);
        write_byte(1023, 8'hC4);
        rst_n = 1'b1;
        for (int k = 0; k < 7; k++) begin @(posedge clk); @(negedge clk); end
        run_cell("R11 odd byte narrow",  14'd5,    5'd2, 1'b1, 1'b0, 1'b0);
        run_cell("R11 even byte narrow", 14'd4,    5'd6, 1'b1, 1'b0, 1'b0);
        run_cell("R11 pair wide",        14'd2,    5'd3, 1'b1, 1'b0, 1'b1);
        run_cell("R11 top byte narrow",  14'd1023, 5'd0, 1'b1, 1'b0, 1'b0);
        run_cell("R4 R3 inverted code on tall line", 14'd5, 5'd9, 1'b1, 1'b0, 1'b0);

        summary();
    end
endmodule